// File: doc/BRIEF.md
# Low-Power Control Register with Sequencer-Owned Lock

This block holds the software-visible control word that tells the power sequencer what to do on the next sleep. The word carries a one-bit low-power intent and five settings that take effect while the chip is asleep: core clock on, IO clock on, USB clock on, USB clock on while awake, and keep the main power domain on. Software writes and reads the word through a plain single-cycle write port and a continuous readback bus. The decoded settings go straight to the clock and power controls.

The write enable for the word is not software's to change. A two-state lock machine closes the word when the sequencer signals that sleep entry has begun. It reopens the word when the sequencer signals that the system is back in the active state, whatever caused the return. The intent bit is cleared by hardware when entry begins and when a reset request is accepted, so a stale intent never survives into the next period of activity.

The lock machine has two states. ST_OPEN is the reset state, and in it writes are accepted. ST_SEALED means writes are dropped. The transition SEAL goes from ST_OPEN to ST_SEALED on the entry-start pulse. The transition UNSEAL goes from ST_SEALED to ST_OPEN on the returned-to-active pulse. Any illegal encoding of the state register falls into ST_SEALED.

Top module: `lp_ctrl_reg`

## Requirements
- R1: After reset, lock_open_o is 1 and rd_data_o reads 0x180, which is bits 7 and 8 set and all other bits 0.
- R2: A cycle with entry_start_i high while the lock is open makes lock_open_o 0 from the next cycle on.
- R3: A cycle with active_return_i high while the lock is closed makes lock_open_o 1 from the next cycle on.
- R4: While lock_open_o is 0, a write leaves rd_data_o unchanged, except that the intent bit may still be cleared by hardware.
- R5: While lock_open_o is 1, a write loads these bits of wr_data_i into the word in the next cycle: bit 0 intent, bit 4 core clock in sleep, bit 5 IO clock in sleep, bit 6 USB clock in sleep, bit 7 USB clock when active, bit 8 keep the main domain powered (0 means the main domain powers down). All other rd_data_o bits always read 0.
- R6: A cycle with entry_start_i or rst_req_accept_i high makes the intent bit 0 in the next cycle. This holds even when a write of intent 1 arrives in the same cycle.
- R7: usb_clk_slp_o is 1 only when both bit 6 and bit 8 of the word are 1. Readback still shows bit 6 as it was written.
- R8: hint_o, core_clk_slp_o, io_clk_slp_o, usb_clk_act_o and main_keep_o equal bits 0, 4, 5, 7 and 8 of the word.
- R9: The lock changes only on those two pulses. An open lock stays open without entry_start_i, and a closed lock stays closed without active_return_i.
- R10: A write in the same cycle as entry_start_i, while the lock is still open, still loads bits 4 to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Software write strobe, one cycle |
| wr_data_i | input | DW | Software write data |
| rd_data_o | output | DW | Readback of the control word |
| lock_open_o | output | 1 | Read-only lock bit, 1 when writes are accepted |
| entry_start_i | input | 1 | Sequencer pulse: sleep entry has begun |
| active_return_i | input | 1 | Sequencer pulse: back in the active state |
| rst_req_accept_i | input | 1 | Sequencer pulse: a reset request was taken |
| hint_o | output | 1 | Low-power intent for the next wait-for-interrupt |
| core_clk_slp_o | output | 1 | Core clock stays on during sleep |
| io_clk_slp_o | output | 1 | IO clock stays on during sleep |
| usb_clk_slp_o | output | 1 | USB clock stays on during sleep, after gating by bit 8 |
| usb_clk_act_o | output | 1 | USB clock on while active |
| main_keep_o | output | 1 | Main domain kept powered during sleep |

## Verification
The hardest cases to reach are the coincidences. One is a write that lands in the same cycle as a sequencer pulse, either entry start or a reset-request acceptance, which race against the write of intent 1. The other is a write that arrives in the first cycle after the lock reopens. Directed sequences line these up on purpose. After them, a long stretch driven by a free-running LFSR places writes and pulses on every combination of cycles. The model computes the expected word and lock state on each of those cycles, and the bench compares them with the outputs on every clock.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

    // Field index within the stored control word
    localparam int unsigned NUM_FLD   = 6;
    localparam int unsigned F_HINT    = 0;
    localparam int unsigned F_CORE    = 1;
    localparam int unsigned F_IO      = 2;
    localparam int unsigned F_USB_SLP = 3;
    localparam int unsigned F_USB_ACT = 4;
    localparam int unsigned F_MAIN    = 5;

    // Bit position of each field in the software word (decoded by software)
    function automatic int unsigned fld_pos(input int unsigned idx);
        case (idx)
            0:       fld_pos = 0;
            1:       fld_pos = 4;
            2:       fld_pos = 5;
            3:       fld_pos = 6;
            4:       fld_pos = 7;
            default: fld_pos = 8;
        endcase
    endfunction

    // Reset value per field index: USB active clock and main keep are on
    localparam logic [NUM_FLD-1:0] FLD_RST = 6'b110000;

    typedef enum logic [1:0] {
        ST_OPEN   = 2'b01,
        ST_SEALED = 2'b10
    } lock_state_e;

    typedef struct packed {
        logic hint;
        logic core_slp;
        logic io_slp;
        logic usb_slp;
        logic usb_act;
        logic main_keep;
    } lp_out_t;

endpackage

// File: rtl/lpc_lock_fsm.sv
module lpc_lock_fsm
    import lpc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic entry_start_i,
    input  logic active_return_i,
    output logic open_o
);

    lock_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN:   if (entry_start_i)   state_d = ST_SEALED;
            ST_SEALED: if (active_return_i) state_d = ST_OPEN;
            default:                        state_d = ST_SEALED;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_OPEN;
        else         state_q <= state_d;
    end

    always_comb begin
        open_o = 1'b0;
        unique case (state_q)
            ST_OPEN:   open_o = 1'b1;
            ST_SEALED: open_o = 1'b0;
            default:   open_o = 1'b0;
        endcase
    end

    // R2
    p_seal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (open_o && entry_start_i) |=> !open_o);
    // R3
    p_unseal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!open_o && active_return_i) |=> open_o);
    // R9
    p_hold_open_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (open_o && !entry_start_i) |=> open_o);
    p_hold_sealed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!open_o && !active_return_i) |=> !open_o);

endmodule

// File: rtl/lpc_fields.sv
module lpc_fields
    import lpc_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              lock_open_i,
    input  logic              wr_en_i,
    input  logic [DW-1:0]     wr_data_i,
    input  logic              hint_clr_i,
    output logic [NUM_FLD-1:0] fld_o,
    output logic [DW-1:0]     rd_data_o
);

    logic               wr_ok;
    logic [NUM_FLD-1:0] fld_q;
    logic               unused_wr;

    assign wr_ok     = wr_en_i && lock_open_i;
    assign unused_wr = ^wr_data_i;

    for (genvar i = 0; i < NUM_FLD; i++) begin : g_fld
        localparam int unsigned POS = fld_pos(i);
        if (i == F_HINT) begin : g_hint
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni)         fld_q[i] <= FLD_RST[i];
                else if (hint_clr_i) fld_q[i] <= 1'b0;
                else if (wr_ok)      fld_q[i] <= wr_data_i[POS];
            end
        end else begin : g_plain
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni)    fld_q[i] <= FLD_RST[i];
                else if (wr_ok) fld_q[i] <= wr_data_i[POS];
            end
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int unsigned k = 0; k < NUM_FLD; k++) begin
            rd_data_o[fld_pos(k)] = fld_q[k];
        end
    end

    assign fld_o = fld_q;

    // R4
    p_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lock_open_i |=> $stable(fld_q[NUM_FLD-1:1]));
    p_no_hint_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lock_open_i |=> !$rose(fld_q[F_HINT]));
    // R6
    p_hint_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hint_clr_i |=> !fld_q[F_HINT]);

endmodule

// File: rtl/lpc_decode.sv
module lpc_decode
    import lpc_pkg::*;
(
    input  logic [NUM_FLD-1:0] fld_i,
    output lp_out_t            out_o
);

    always_comb begin
        out_o.hint      = fld_i[F_HINT];
        out_o.core_slp  = fld_i[F_CORE];
        out_o.io_slp    = fld_i[F_IO];
        out_o.usb_act   = fld_i[F_USB_ACT];
        out_o.main_keep = fld_i[F_MAIN];
        out_o.usb_slp   = fld_i[F_USB_SLP] && fld_i[F_MAIN];
    end

endmodule

// File: rtl/lp_ctrl_reg.sv
module lp_ctrl_reg
    import lpc_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    output logic [DW-1:0] rd_data_o,
    output logic          lock_open_o,
    input  logic          entry_start_i,
    input  logic          active_return_i,
    input  logic          rst_req_accept_i,
    output logic          hint_o,
    output logic          core_clk_slp_o,
    output logic          io_clk_slp_o,
    output logic          usb_clk_slp_o,
    output logic          usb_clk_act_o,
    output logic          main_keep_o
);

    logic [NUM_FLD-1:0] fld;
    lp_out_t            dec;
    logic               hint_clr;

    assign hint_clr = entry_start_i || rst_req_accept_i;

    lpc_lock_fsm u_lock (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .entry_start_i   (entry_start_i),
        .active_return_i (active_return_i),
        .open_o          (lock_open_o)
    );

    lpc_fields #(.DW(DW)) u_fields (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .lock_open_i (lock_open_o),
        .wr_en_i     (wr_en_i),
        .wr_data_i   (wr_data_i),
        .hint_clr_i  (hint_clr),
        .fld_o       (fld),
        .rd_data_o   (rd_data_o)
    );

    lpc_decode u_dec (
        .fld_i (fld),
        .out_o (dec)
    );

    assign hint_o         = dec.hint;
    assign core_clk_slp_o = dec.core_slp;
    assign io_clk_slp_o   = dec.io_slp;
    assign usb_clk_slp_o  = dec.usb_slp;
    assign usb_clk_act_o  = dec.usb_act;
    assign main_keep_o    = dec.main_keep;

    // R7
    p_usb_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        usb_clk_slp_o |-> (rd_data_o[8] && rd_data_o[6]));
    // R8
    p_core_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_clk_slp_o == rd_data_o[4]);
    // R6 at the ports
    p_rstreq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_accept_i |=> !hint_o);

endmodule

// File: tb/sim_lp_ctrl_reg.sv
`timescale 1ns/1ps
module sim_lp_ctrl_reg;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          es = 1'b0, ar = 1'b0, rq = 1'b0;
    logic [DW-1:0] rd_data;
    logic          lock_open, hint, core_s, io_s, usb_s, usb_a, main_k;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // Reference state
    bit       m_lock;
    bit [8:0] m_word;

    always #5 clk = ~clk;

    lp_ctrl_reg #(.DW(DW)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_data_o(rd_data), .lock_open_o(lock_open), .entry_start_i(es),
        .active_return_i(ar), .rst_req_accept_i(rq), .hint_o(hint),
        .core_clk_slp_o(core_s), .io_clk_slp_o(io_s), .usb_clk_slp_o(usb_s),
        .usb_clk_act_o(usb_a), .main_keep_o(main_k)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_lock = 1'b1;
            m_word = 9'h180;
        end else begin
            bit accept;
            accept = m_lock && wr_en;
            if (accept) begin
                m_word[8:4] = wr_data[8:4];
                m_word[0]   = wr_data[0];
            end
            if (es || rq) m_word[0] = 1'b0;
            if (m_lock && es)       m_lock = 1'b0;
            else if (!m_lock && ar) m_lock = 1'b1;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk("R2/R3/R9", {tag, " lock"}, lock_open, m_lock);
        chk("R4/R5", {tag, " word"}, rd_data, {23'd0, m_word});
        chk("R8", {tag, " hint"}, hint, m_word[0]);
        chk("R8", {tag, " core"}, core_s, m_word[4]);
        chk("R8", {tag, " io"}, io_s, m_word[5]);
        chk("R7", {tag, " usb_slp"}, usb_s, m_word[6] & m_word[8]);
        chk("R8", {tag, " usb_act"}, usb_a, m_word[7]);
        chk("R8", {tag, " main"}, main_k, m_word[8]);
    endtask

    task automatic cyc(input bit w, input logic [DW-1:0] d, input bit e, input bit a, input bit r, input string tag);
        wr_en = w; wr_data = d; es = e; ar = a; rq = r;
        @(posedge clk); #1;
        compare_all(tag);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        #22;
        // R1 reset state
        chk("R1", "reset lock", lock_open, 1);
        chk("R1", "reset word", rd_data, 32'h180);
        rst_n = 1'b1;
        #1;
        cyc(0, '0, 0, 0, 0, "R1 idle");
        // R5 writes while open, reserved bits read 0
        cyc(1, 32'hFFFF_FFFF, 0, 0, 0, "R5 all ones");
        chk("R5", "reserved bits", rd_data & ~32'h1F1, 0);
        cyc(1, 32'h0000_0050, 0, 0, 0, "R5 usb_slp+core");
        // R7 main powers down with usb sleep bit set
        cyc(1, 32'h0000_0040, 0, 0, 0, "R7 gated");
        chk("R7", "usb gated", usb_s, 0);
        chk("R7", "bit6 readback", rd_data[6], 1);
        // R6 write of hint with reset request same cycle
        cyc(1, 32'h0000_0131, 0, 0, 1, "R6 rq vs write");
        chk("R6", "hint after rq", hint, 0);
        cyc(1, 32'h0000_0001, 0, 0, 0, "R5 hint set");
        // R10 write with entry start same cycle
        cyc(1, 32'h0000_01A1, 1, 0, 0, "R10 write+seal");
        chk("R10", "fields loaded", rd_data, 32'h1A0);
        chk("R2", "sealed", lock_open, 0);
        // R4 writes ignored while sealed
        cyc(1, 32'h0000_0071, 0, 0, 0, "R4 ignored");
        chk("R4", "word frozen", rd_data, 32'h1A0);
        cyc(0, '0, 1, 0, 0, "R9 es while sealed");
        chk("R9", "still sealed", lock_open, 0);
        // R3 reopen, then write on the first open cycle
        cyc(1, 32'h0000_0011, 0, 1, 0, "R3 reopen");
        chk("R3", "reopened", lock_open, 1);
        chk("R4", "write at reopen dropped", rd_data, 32'h1A0);
        cyc(1, 32'h0000_0011, 0, 0, 0, "R5 first open write");
        chk("R5", "write after reopen", rd_data, 32'h011);
        // Free-running stimulus
        lf = 16'hACE1;
        for (int n = 0; n < 4000; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            cyc(lf[8], {lf, lf ^ 16'(n)}, lf[3:0] == 4'd0, lf[7:5] == 3'd1,
                lf[12:9] == 4'd3, "LFSR");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule